// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block sends a 28-bit parallel display word (three 8-bit colour channels, horizontal sync, vertical sync, data enable and one spare control bit) over four serial data lanes plus one forwarded clock lane. Once per pixel clock period it captures the word and spreads it over the four lanes, seven bits per lane. Each lane therefore runs at seven times the pixel rate, for example 455 Mb/s per lane at a 65 MHz pixel clock. The block works over the whole 20 MHz to 65 MHz pixel range, because it keys only on the edges of its two clocks.

The block takes the pixel clock and a bit clock that runs at seven times that rate with a fixed phase to it. The multiplying PLL and the analog differential drivers are outside the block. The block recovers the pixel phase itself: it samples the pixel clock on the bit clock and restarts its slot counter from each pixel rising edge. An active-low power-down input releases the pads by dropping the output enable. After power-up, a ready flag stays low for a programmable lock interval. The nominal interval is 10 ms, given as a count of bit-clock cycles.

The pixel falling edge must fall between the pixel rising edge and the bit edge at which the slot counter reaches its last slot. A pixel clock that is high for four bit periods and low for three meets this.

Top module: `pixlink_ser7`

## Requirements
- R1: The parallel word is captured on the falling edge of `clk_pix`. Values on `pix_word` at any other time within the pixel period have no effect on the lanes.
- R2: Input bits 7k to 7k+6 leave on `lane_o[k]`. Bit 7k goes out in slot 0 and bit 7k+6 in slot 6, one bit per bit-clock cycle.
- R3: `clk_lane_o` repeats 1,1,0,0,0,1,1 over slots 0 to 6, so it is high for four slots and low for three. Its slot 0 coincides with slot 0 of every data lane, and the pattern recurs every seven bit-clock cycles while `oe_o` is high.
- R4: Every captured word leaves as exactly one complete frame. Frames come out in capture order, one per pixel period, and a word's frame starts within two pixel periods of its capture.
- R5: `oe_o` falls at the third bit-clock rising edge after `pwr_n` goes low. It rises at the third bit-clock rising edge after `pwr_n` goes high, or after reset is released with `pwr_n` high. At 455 MHz this is far inside 100 ns.
- R6: While `oe_o` is low, all data lanes and the clock lane are driven to 0.
- R7: `ready_o` is low whenever `oe_o` is low. It rises exactly LOCK_CYCLES bit-clock cycles after `oe_o` rises.
- R8: While `rst` is high, `oe_o`, `ready_o`, `clk_lane_o` and every lane output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock, seven times the pixel rate, fixed phase to `clk_pix` |
| clk_pix | input | 1 | Pixel clock; its falling edge strobes `pix_word` |
| rst | input | 1 | Synchronous active-high reset |
| pwr_n | input | 1 | Active-low power-down request (asynchronous) |
| pix_word | input | LANES*SLOTS | Parallel pixel word: colour bits and control lines |
| lane_o | output | LANES | Serial data lane bits, one per bit-clock cycle |
| clk_lane_o | output | 1 | Forwarded framing clock lane bit |
| oe_o | output | 1 | Pad output enable; low releases the lanes to high impedance |
| ready_o | output | 1 | High once the lock interval has passed |

## Verification
The bench builds the block with four lanes of seven slots, two synchronizer stages and LOCK_CYCLES set to 40 instead of the multi-million default. Because of the short lock wait, an exact measurement of the lock interval fits into one run twice: after reset and after a power-down recovery. The bit clock runs at 50 MHz and the pixel clock at one seventh of that. The bench holds each word on the input only around the falling pixel edge, with decoy values elsewhere in the period. It reassembles frames from the lanes using only the clock-lane pattern, and sends walking-one words so that each of the 28 bit positions is traced to its own lane and slot.

// File: rtl/ser7_pkg.sv
`timescale 1ns/1ps
// Shared defaults and types for the seven-to-one display serializer.
package ser7_pkg;
  localparam int DEF_LANES       = 4;
  localparam int DEF_SLOTS       = 7;
  localparam int DEF_SYNC_STAGES = 2;
  // 10 ms at 455 MHz bit rate
  localparam int DEF_LOCK_CYCLES = 4_550_000;
  // bit i is the clock-lane level during slot i: 1,1,0,0,0,1,1
  localparam logic [DEF_SLOTS-1:0] DEF_CLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    PW_OFF  = 2'd0,
    PW_LOCK = 2'd1,
    PW_RUN  = 2'd2
  } pw_state_e;
endpackage

// File: rtl/ser7_capture.sv
`timescale 1ns/1ps
// Falling-edge pixel capture plus the holding register in the bit domain.
module ser7_capture #(
  parameter int WORD_W = 28
) (
  input  logic              clk_pix,
  input  logic              clk_bit,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic              hold_ld,
  output logic [WORD_W-1:0] hold_q
);
  logic [WORD_W-1:0] cap_q;

  always_ff @(negedge clk_pix) begin
    if (rst) cap_q <= '0;
    else     cap_q <= din;
  end

  // loaded once per pixel period, well after the falling edge settled cap_q
  always_ff @(posedge clk_bit) begin
    if (rst)          hold_q <= '0;
    else if (hold_ld) hold_q <= cap_q;
  end
endmodule

// File: rtl/ser7_slot_ctrl.sv
`timescale 1ns/1ps
// Slot counter locked to the pixel clock phase, and the clock-lane register.
module ser7_slot_ctrl #(
  parameter int               SLOTS       = 7,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011,
  parameter int               SLOT_W      = 3
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              clk_pix,
  input  logic              run,
  output logic [SLOT_W-1:0] slot_q,
  output logic              clk_lane_q
);
  // two sampling stages put the detected pixel rise two counts in
  localparam int PIX_STAGES  = 2;
  localparam int RESYNC_SLOT = PIX_STAGES;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [PIX_STAGES-1:0] pix_s;
  logic                  pix_rise;

  always_ff @(posedge clk_bit) begin
    if (rst) pix_s <= '0;
    else     pix_s <= {pix_s[PIX_STAGES-2:0], clk_pix};
  end

  assign pix_rise = pix_s[0] & ~pix_s[1];

  always_ff @(posedge clk_bit) begin
    if (rst)               slot_q <= '0;
    else if (pix_rise)     slot_q <= SLOT_W'(RESYNC_SLOT);
    else if (slot_q == LAST) slot_q <= '0;
    else                   slot_q <= slot_q + 1'b1;
  end

  // the level shown after an edge belongs to the slot counted before it
  always_ff @(posedge clk_bit) begin
    if (rst || !run) clk_lane_q <= 1'b0;
    else             clk_lane_q <= CLK_PATTERN[slot_q];
  end
endmodule

// File: rtl/ser7_lanes.sv
`timescale 1ns/1ps
// One shift register per data lane, loaded from the holding register.
module ser7_lanes #(
  parameter int LANES = 4,
  parameter int SLOTS = 7
) (
  input  logic                   clk_bit,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   sh_ld,
  input  logic [LANES*SLOTS-1:0] hold,
  output logic [LANES-1:0]       lane_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLOTS-1:0] sh_q;

    always_ff @(posedge clk_bit) begin
      if (rst || !run) sh_q <= '0;
      else if (sh_ld)  sh_q <= hold[k*SLOTS +: SLOTS];
      else             sh_q <= {1'b0, sh_q[SLOTS-1:1]};
    end

    assign lane_o[k] = sh_q[0];
  end
endmodule

// File: rtl/ser7_power.sv
`timescale 1ns/1ps
// Power-down synchronizer, output enable and the lock-wait counter.
module ser7_power
  import ser7_pkg::*;
#(
  parameter int LOCK_CYCLES = 4_550_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_bit,
  input  logic rst,
  input  logic pwr_n,
  output logic run,
  output logic oe_q,
  output logic ready_q
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  pw_state_e              st_q;

  always_ff @(posedge clk_bit) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pwr_n};
  end

  assign run = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_bit) begin
    if (rst || !run) begin
      st_q    <= PW_OFF;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      oe_q <= 1'b1;
      unique case (st_q)
        PW_OFF: begin
          st_q  <= PW_LOCK;
          cnt_q <= '0;
        end
        PW_LOCK: begin
          if (cnt_q == CNT_LAST) begin
            st_q    <= PW_RUN;
            ready_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PW_RUN:  ready_q <= 1'b1;
        default: st_q <= PW_OFF;
      endcase
    end
  end
endmodule

// File: rtl/pixlink_ser7.sv
`timescale 1ns/1ps
// Top: 28-bit pixel word to four 7:1 serial lanes plus a framing clock lane.
module pixlink_ser7
  import ser7_pkg::*;
#(
  parameter int               LANES       = DEF_LANES,
  parameter int               SLOTS       = DEF_SLOTS,
  parameter logic [SLOTS-1:0] CLK_PATTERN = DEF_CLK_PATTERN,
  parameter int               LOCK_CYCLES = DEF_LOCK_CYCLES,
  parameter int               SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                   clk_bit,
  input  logic                   clk_pix,
  input  logic                   rst,
  input  logic                   pwr_n,
  input  logic [LANES*SLOTS-1:0] pix_word,
  output logic [LANES-1:0]       lane_o,
  output logic                   clk_lane_o,
  output logic                   oe_o,
  output logic                   ready_o
);
  localparam int WORD_W = LANES * SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] slot_w;
  logic [WORD_W-1:0] hold_w;
  logic              run_w;
  logic              hold_ld;
  logic              sh_ld;

  assign hold_ld = (slot_w == SLOT_W'(SLOTS - 1));
  assign sh_ld   = (slot_w == '0);

  ser7_power #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_power (
    .clk_bit (clk_bit),
    .rst     (rst),
    .pwr_n   (pwr_n),
    .run     (run_w),
    .oe_q    (oe_o),
    .ready_q (ready_o)
  );

  ser7_slot_ctrl #(
    .SLOTS       (SLOTS),
    .CLK_PATTERN (CLK_PATTERN),
    .SLOT_W      (SLOT_W)
  ) u_slot (
    .clk_bit    (clk_bit),
    .rst        (rst),
    .clk_pix    (clk_pix),
    .run        (run_w),
    .slot_q     (slot_w),
    .clk_lane_q (clk_lane_o)
  );

  ser7_capture #(
    .WORD_W (WORD_W)
  ) u_cap (
    .clk_pix (clk_pix),
    .clk_bit (clk_bit),
    .rst     (rst),
    .din     (pix_word),
    .hold_ld (hold_ld),
    .hold_q  (hold_w)
  );

  ser7_lanes #(
    .LANES (LANES),
    .SLOTS (SLOTS)
  ) u_lanes (
    .clk_bit (clk_bit),
    .rst     (rst),
    .run     (run_w),
    .sh_ld   (sh_ld),
    .hold    (hold_w),
    .lane_o  (lane_o)
  );
endmodule

// File: rtl/pixlink_ser7_chk.sv
`timescale 1ns/1ps
// Property checker, attached to the top module by bind.
module pixlink_ser7_chk #(
  parameter int LANES       = 4,
  parameter int SLOTS       = 7,
  parameter int SYNC_STAGES = 2
) (
  input logic                       clk_bit,
  input logic                       rst,
  input logic                       pwr_n,
  input logic [LANES-1:0]           lane_o,
  input logic                       clk_lane_o,
  input logic                       oe_o,
  input logic                       ready_o,
  input logic [$clog2(SLOTS)-1:0]   slot,
  input logic [LANES*SLOTS-1:0]     hold
);
  localparam int SLOT_W = $clog2(SLOTS);

  // R6: pads quiet while disabled
  assert_quiet_off_R6: assert property (@(posedge clk_bit) disable iff (rst)
    !oe_o |-> (lane_o == '0 && !clk_lane_o));

  // R7: ready never without output enable
  assert_ready_needs_oe_R7: assert property (@(posedge clk_bit) disable iff (rst)
    ready_o |-> oe_o);

  assert_ready_after_oe_R7: assert property (@(posedge clk_bit) disable iff (rst)
    $rose(ready_o) |-> $past(oe_o));

  // R3: clock lane high runs last at least two slots, low runs three
  assert_clk_high_run_R3: assert property (@(posedge clk_bit) disable iff (rst)
    (oe_o && $past(oe_o) && $rose(clk_lane_o)) |=> (clk_lane_o || !oe_o));

  assert_clk_low_run_R3: assert property (@(posedge clk_bit) disable iff (rst)
    (oe_o && $past(oe_o) && $fell(clk_lane_o)) |=> !clk_lane_o);

  // R4: slot counter stays in range and the holding register moves only on the last slot
  assert_slot_range_R4: assert property (@(posedge clk_bit) disable iff (rst)
    slot < SLOT_W'(SLOTS));

  assert_hold_on_last_slot_R4: assert property (@(posedge clk_bit) disable iff (rst)
    !$stable(hold) |-> ($past(slot) == SLOT_W'(SLOTS - 1)));

  // R5: output enable gone three edges into a power-down request
  if (SYNC_STAGES == 2) begin : g_pd
    assert_pd_release_R5: assert property (@(posedge clk_bit) disable iff (rst)
      (!pwr_n && $past(!pwr_n) && $past(!pwr_n, 2)) |=> !oe_o);
  end
endmodule

bind pixlink_ser7 pixlink_ser7_chk #(
  .LANES       (LANES),
  .SLOTS       (SLOTS),
  .SYNC_STAGES (SYNC_STAGES)
) chk_i (
  .clk_bit    (clk_bit),
  .rst        (rst),
  .pwr_n      (pwr_n),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .oe_o       (oe_o),
  .ready_o    (ready_o),
  .slot       (slot_w),
  .hold       (hold_w)
);

// File: tb/pixlink_ser7_tb_top.sv
`timescale 1ns/1ps
module pixlink_ser7_tb_top;
  localparam int LANES  = 4;
  localparam int SLOTS  = 7;
  localparam int LOCK   = 40;
  localparam int W      = LANES * SLOTS;
  localparam int PIX_NS = 140;

  logic         clk_bit = 1'b0;
  logic         clk_pix = 1'b0;
  logic         rst     = 1'b1;
  logic         pwr_n   = 1'b1;
  logic [W-1:0] din     = '0;
  logic [LANES-1:0] lane_o;
  logic         clk_lane_o, oe_o, ready_o;

  int checks = 0;
  int errors = 0;
  bit track  = 1'b0;
  bit done   = 1'b0;

  logic [W-1:0] exp_q[$];
  time          t_q[$];

  pixlink_ser7 #(
    .LANES       (LANES),
    .SLOTS       (SLOTS),
    .LOCK_CYCLES (LOCK),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk_bit    (clk_bit),
    .clk_pix    (clk_pix),
    .rst        (rst),
    .pwr_n      (pwr_n),
    .pix_word   (din),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o),
    .oe_o       (oe_o),
    .ready_o    (ready_o)
  );

  // 50 MHz bit clock; pixel clock one seventh, high 4 bit periods, low 3
  always #10 clk_bit = ~clk_bit;

  initial begin
    #20;
    forever begin
      clk_pix = 1'b1; #80;
      clk_pix = 1'b0; #60;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: the word is valid only around the falling pixel edge (R1 decoys)
  task automatic send(input logic [W-1:0] w);
    @(posedge clk_pix);
    din = ~w;
    #60 din = w;
    #20;
    if (track) begin
      exp_q.push_back(w);
      t_q.push_back($time);
    end
    #20 din = w ^ 28'h5A5_A5A5;
  endtask

  // monitor: frames the lanes with the clock-lane pattern and scores them
  logic [SLOTS-1:0] clkh = '0;
  logic [SLOTS-1:0] lh [LANES];
  int oe_run = 0;
  int smp = 0;
  int last_det = 0;
  initial for (int k = 0; k < LANES; k++) lh[k] = '0;

  always @(negedge clk_bit) begin
    logic [W-1:0] got;
    logic [W-1:0] exp;
    clkh = {clkh[SLOTS-2:0], clk_lane_o};
    for (int k = 0; k < LANES; k++) lh[k] = {lh[k][SLOTS-2:0], lane_o[k]};
    smp++;
    oe_run = (oe_o && !rst) ? oe_run + 1 : 0;
    if (oe_run >= SLOTS && clkh == 7'b1100011) begin
      if (oe_run >= 2 * SLOTS)
        chk(smp - last_det == SLOTS, "R3 clock-lane period", smp - last_det, SLOTS);
      last_det = smp;
      for (int k = 0; k < LANES; k++)
        for (int j = 0; j < SLOTS; j++)
          got[k*SLOTS + j] = lh[k][SLOTS-1-j];
      if (exp_q.size() > 0 && ($time - t_q[0]) >= PIX_NS) begin
        exp = exp_q.pop_front();
        void'(t_q.pop_front());
        chk(got == exp, "R1 R2 R4 frame word", {4'h0, got}, {4'h0, exp});
      end
    end
  end

  task automatic wake_check(input string what);
    int n_oe;
    int n_rdy;
    n_oe = 0;
    do begin @(negedge clk_bit); n_oe++; end while (!oe_o && n_oe < 50);
    chk(n_oe == 3, {"R5 oe rise ", what}, n_oe, 3);
    n_rdy = 0;
    while (!ready_o && n_rdy < LOCK + 20) begin
      @(negedge clk_bit);
      n_rdy++;
    end
    chk(n_rdy == LOCK, {"R7 lock wait ", what}, n_rdy, LOCK);
  endtask

  task automatic drain(input string what);
    repeat (4 * SLOTS) @(negedge clk_bit);
    chk(exp_q.size() == 0, {"R4 all words delivered ", what}, exp_q.size(), 0);
  endtask

  initial begin : main
    logic [W-1:0] w;
    repeat (10) @(negedge clk_bit);
    // R8 reset state
    chk(oe_o == 1'b0, "R8 oe in reset", oe_o, 0);
    chk(ready_o == 1'b0, "R8 ready in reset", ready_o, 0);
    chk({lane_o, clk_lane_o} == '0, "R8 lanes in reset", {lane_o, clk_lane_o}, 0);
    rst = 1'b0;
    wake_check("after reset");

    track = 1'b1;
    // R2 walking ones: each input bit to its own lane and slot
    for (int b = 0; b < W; b++) send(28'(1) << b);
    send('0);
    send('1);
    send(28'hAAA_AAAA);
    send(28'h555_5555);
    for (int i = 0; i < 8; i++) send(28'($urandom));
    track = 1'b0;
    drain("first run");

    // power-down
    @(negedge clk_bit);
    pwr_n = 1'b0;
    @(negedge clk_bit);
    @(negedge clk_bit);
    chk(oe_o == 1'b1, "R5 oe still up two edges after request", oe_o, 1);
    @(negedge clk_bit);
    chk(oe_o == 1'b0, "R5 oe down at third edge", oe_o, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_bit);
      chk({lane_o, clk_lane_o} == '0, "R6 lanes quiet in power-down", {lane_o, clk_lane_o}, 0);
      chk(ready_o == 1'b0, "R7 ready low in power-down", ready_o, 0);
    end
    exp_q.delete();
    t_q.delete();
    @(negedge clk_bit);
    pwr_n = 1'b1;
    wake_check("after power-down");

    track = 1'b1;
    for (int i = 0; i < 16; i++) begin
      w = 28'($urandom);
      send(w);
    end
    send(28'h8000001);
    track = 1'b0;
    drain("after recovery");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #3_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule